// File: doc/BRIEF.md
# Paired-Row Integer Register File with Store-Double Read

This block is a 32-word by 64-bit integer register file for an execution pipeline. Its storage is arranged as sixteen rows, and each row holds one even and one odd register. It has three addressed read ports and one synchronous write port. Each read port decodes the upper address bits to pick a row. It then uses the lowest address bit to choose the even or the odd word of that row. All reads are combinational.

The third read port has a companion output, the high tap. The high tap has no address of its own. It always returns the odd word of the row that the third port has selected. This lets a store-double instruction fetch its whole operand from one even address in a single cycle. The low 64 bits of that operand come from the third port, and the upper 32 bits come from the low half of the high tap.

The block also returns the assembled 96-bit store operand. It flags a store-double request whose address is odd. Every pin is plain control or data with no handshake: a read is valid in the same cycle its address is presented, and the block never stalls, so no back-pressure exists.

Top module: `pairrow_regfile`

## Requirements
- R1: While `rst` is high at a rising clock edge, all 32 registers become zero, and every read port then returns 0.
- R2: With `wr_en` high, the register at `wr_addr` takes `wr_data` at the rising clock edge, and a later read of that address returns it.
- R3: `rd1_data`, `rd2_data` and `rd3_data` each return the register named by their own 5-bit address, combinationally. The row is address bits [4:1], and bit 0 selects the odd (1) or even (0) word.
- R4: A read of a register in the same cycle that it is being written returns the value it held before the write. There is no bypass.
- R5: `rd3_hi_data` returns the register at address {`rd3_addr`[4:1], 1}, whatever the value of `rd3_addr`[0].
- R6: When `rd3_addr`[0] is 1, `rd3_data` equals `rd3_hi_data` in all 64 bits.
- R7: `sd_data`[63:0] equals `rd3_data`, and `sd_data`[95:64] equals `rd3_hi_data`[31:0].
- R8: `sd_misalign` is 1 exactly when `sd_req` is 1 and `rd3_addr`[0] is 1. Otherwise it is 0.
- R9: With `wr_en` low, no register changes at a clock edge, whatever the values on `wr_addr` and `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Active-high synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Register written |
| wr_data | input | 64 | Value written |
| rd1_addr | input | 5 | Address of read port 1 |
| rd1_data | output | 64 | Read port 1 result |
| rd2_addr | input | 5 | Address of read port 2 |
| rd2_data | output | 64 | Read port 2 result |
| rd3_addr | input | 5 | Address of read port 3; also selects the row for the high tap |
| rd3_data | output | 64 | Read port 3 result |
| rd3_hi_data | output | 64 | Odd word of the row chosen by port 3 |
| sd_req | input | 1 | Marks the port-3 read as a store-double |
| sd_data | output | 96 | Assembled store-double operand |
| sd_misalign | output | 1 | Store-double requested with an odd port-3 address |

## Verification
The file is loaded with a distinct arithmetic pattern in every register. The sweep then covers every address on port 3, while ports 1 and 2 walk the file in opposite directions. This separates row decoding from even/odd selection and catches any swap between ports.

Because the port-3 sweep covers both parities, it shows the high tap ignoring the low address bit. It also shows odd addresses giving equal words on port 3 and the high tap. The misalign flag and the 96-bit operand are checked for both values of the store-double request.

A write cycle is sampled both before and after its edge to tell bypass from no bypass. An edge with the write strobe low carries live data, and a full read-back after it shows that nothing moved.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int unsigned PRF_REGS   = 32;
  localparam int unsigned PRF_DATA_W = 64;
  localparam int unsigned PRF_HI_W   = 32;
  localparam int unsigned PRF_RPORTS = 3;

  // Word choice inside a row, driven by the lowest address bit
  typedef enum logic {
    WORD_EVEN = 1'b0,
    WORD_ODD  = 1'b1
  } word_sel_e;
endpackage

// File: rtl/prf_row_array.sv
module prf_row_array #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned NRP      = 3,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
  localparam int unsigned ROW_W   = ADDR_W - 1,
  localparam int unsigned NUM_ROWS = NUM_REGS / 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [NRP-1:0][ROW_W-1:0]      rd_row,
  output logic [NRP-1:0][DATA_W-1:0]     rd_even,
  output logic [NRP-1:0][DATA_W-1:0]     rd_odd
);
  import prf_pkg::*;

  logic [DATA_W-1:0] even_q [NUM_ROWS];
  logic [DATA_W-1:0] odd_q  [NUM_ROWS];

  logic [ROW_W-1:0] wr_row;
  word_sel_e        wr_word;
  assign wr_row  = wr_addr[ADDR_W-1:1];
  assign wr_word = word_sel_e'(wr_addr[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_ROWS; r++) begin
        even_q[r] <= '0;
        odd_q[r]  <= '0;
      end
    end else if (wr_en) begin
      if (wr_word == WORD_ODD) odd_q[wr_row]  <= wr_data;
      else                     even_q[wr_row] <= wr_data;
    end
  end

  // One row decoder per read port; both words of the row leave the array
  for (genvar p = 0; p < NRP; p++) begin : g_rport
    assign rd_even[p] = even_q[rd_row[p]];
    assign rd_odd[p]  = odd_q[rd_row[p]];
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (even_q[0] == '0 && odd_q[NUM_ROWS-1] == '0)); // R1
  AST_EVEN_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr[0]) |=> even_q[$past(wr_row)] == $past(wr_data)); // R2
  AST_ODD_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[0]) |=> odd_q[$past(wr_row)] == $past(wr_data)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(even_q[0]) && $stable(odd_q[NUM_ROWS-1]))); // R9
endmodule

// File: rtl/prf_word_sel.sv
module prf_word_sel #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              sel_odd,
  input  logic [DATA_W-1:0] even_word,
  input  logic [DATA_W-1:0] odd_word,
  output logic [DATA_W-1:0] word_out
);
  import prf_pkg::*;

  always_comb begin
    unique case (word_sel_e'(sel_odd))
      WORD_ODD: word_out = odd_word;
      default:  word_out = even_word;
    endcase
  end
endmodule

// File: rtl/prf_sd_merge.sv
module prf_sd_merge #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned HI_W   = 32,
  localparam int unsigned SD_W  = DATA_W + HI_W
) (
  input  logic              sd_req,
  input  logic              addr_lsb,
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] hi_word,
  output logic [SD_W-1:0]   sd_data,
  output logic              sd_misalign
);
  assign sd_data     = {hi_word[HI_W-1:0], lo_word};
  assign sd_misalign = sd_req & addr_lsb;
endmodule

// File: rtl/pairrow_regfile.sv
module pairrow_regfile #(
  parameter int unsigned NUM_REGS = prf_pkg::PRF_REGS,
  parameter int unsigned DATA_W   = prf_pkg::PRF_DATA_W,
  parameter int unsigned HI_W     = prf_pkg::PRF_HI_W,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
  localparam int unsigned ROW_W   = ADDR_W - 1,
  localparam int unsigned NRP     = prf_pkg::PRF_RPORTS,
  localparam int unsigned SD_W    = DATA_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd1_addr,
  output logic [DATA_W-1:0] rd1_data,
  input  logic [ADDR_W-1:0] rd2_addr,
  output logic [DATA_W-1:0] rd2_data,
  input  logic [ADDR_W-1:0] rd3_addr,
  output logic [DATA_W-1:0] rd3_data,
  output logic [DATA_W-1:0] rd3_hi_data,
  input  logic              sd_req,
  output logic [SD_W-1:0]   sd_data,
  output logic              sd_misalign
);
  logic [NRP-1:0][ADDR_W-1:0] port_addr;
  logic [NRP-1:0][ROW_W-1:0]  port_row;
  logic [NRP-1:0][DATA_W-1:0] port_even;
  logic [NRP-1:0][DATA_W-1:0] port_odd;
  logic [NRP-1:0][DATA_W-1:0] port_word;

  assign port_addr[0] = rd1_addr;
  assign port_addr[1] = rd2_addr;
  assign port_addr[2] = rd3_addr;

  prf_row_array #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NRP(NRP)
  ) u_array (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_row(port_row), .rd_even(port_even), .rd_odd(port_odd)
  );

  for (genvar p = 0; p < NRP; p++) begin : g_port
    assign port_row[p] = port_addr[p][ADDR_W-1:1];
    prf_word_sel #(.DATA_W(DATA_W)) u_sel (
      .sel_odd(port_addr[p][0]),
      .even_word(port_even[p]),
      .odd_word(port_odd[p]),
      .word_out(port_word[p])
    );
  end

  assign rd1_data    = port_word[0];
  assign rd2_data    = port_word[1];
  assign rd3_data    = port_word[2];
  // High tap: odd word of port 3's row, no address bit of its own
  assign rd3_hi_data = port_odd[2];

  prf_sd_merge #(.DATA_W(DATA_W), .HI_W(HI_W)) u_merge (
    .sd_req(sd_req), .addr_lsb(rd3_addr[0]),
    .lo_word(rd3_data), .hi_word(rd3_hi_data),
    .sd_data(sd_data), .sd_misalign(sd_misalign)
  );

  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
    (rd1_addr == rd2_addr) |-> (rd1_data == rd2_data)); // R3
  AST_HI_IS_ODD: assert property (@(posedge clk) disable iff (rst)
    (rd1_addr == {rd3_addr[ADDR_W-1:1], 1'b1}) |-> (rd1_data == rd3_hi_data)); // R5
  AST_ODD_TAP_EQUAL: assert property (@(posedge clk) disable iff (rst)
    rd3_addr[0] |-> (rd3_data == rd3_hi_data)); // R6
  AST_SD_LOW_PART: assert property (@(posedge clk) disable iff (rst)
    sd_data[DATA_W-1:0] == rd3_data); // R7
  AST_MISALIGN_ODD: assert property (@(posedge clk) disable iff (rst)
    sd_misalign |-> (sd_data[SD_W-1:DATA_W] == rd3_data[HI_W-1:0])); // R8
endmodule

// File: tb/sim_pairrow_regfile.sv
module sim_pairrow_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [4:0]  rd1_addr = '0, rd2_addr = '0, rd3_addr = '0;
  logic [63:0] rd1_data, rd2_data, rd3_data, rd3_hi_data;
  logic        sd_req = 1'b0;
  logic [95:0] sd_data;
  logic        sd_misalign;

  int errors = 0;
  int checks = 0;
  logic [63:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  pairrow_regfile u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .rd2_addr(rd2_addr), .rd2_data(rd2_data),
    .rd3_addr(rd3_addr), .rd3_data(rd3_data), .rd3_hi_data(rd3_hi_data),
    .sd_req(sd_req), .sd_data(sd_data), .sd_misalign(sd_misalign)
  );

  function automatic logic [63:0] pat(input int idx, input logic [31:0] seed);
    logic [31:0] i32 = 32'(idx);
    return {seed ^ (i32 * 32'h0101_0101), (i32 * 32'h0010_0001) + ~seed};
  endfunction

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input int a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
  endtask

  task automatic sweep_all();
    for (int a = 0; a < 32; a++) begin
      rd1_addr = 5'(a); rd2_addr = 5'(31 - a); rd3_addr = 5'(a);
      for (int s = 0; s < 2; s++) begin
        sd_req = s[0];
        #1;
        chk("R3 port1", 96'(rd1_data), 96'(model[a]));
        chk("R3 port2", 96'(rd2_data), 96'(model[31 - a]));
        chk("R3 port3", 96'(rd3_data), 96'(model[a]));
        chk("R5 hi tap", 96'(rd3_hi_data), 96'(model[a | 1]));
        if (a % 2 == 1) chk("R6 odd equal", 96'(rd3_data), 96'(rd3_hi_data));
        chk("R7 sd datum", sd_data, {model[a | 1][31:0], model[a]});
        chk("R8 misalign", 96'(sd_misalign), 96'((s == 1) && (a % 2 == 1)));
      end
    end
    sd_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // Dirty the file before reset so R1 is meaningful
    rst = 1'b0;
    for (int a = 0; a < 32; a++) write_reg(a, 64'hDEAD_0000_0000_0000 | 64'(a));
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int a = 0; a < 32; a++) begin
      model[a] = '0;
      rd1_addr = 5'(a); #1;
      chk("R1 reset zero", 96'(rd1_data), 96'(0));
    end

    // R2: load pattern, then full sweep
    for (int a = 0; a < 32; a++) write_reg(a, pat(a, 32'hA5C3_0F1E));
    sweep_all();

    // R4: same-cycle read sees old value, new value after the edge
    @(negedge clk);
    rd1_addr = 5'd6; rd3_addr = 5'd6;
    wr_en = 1'b1; wr_addr = 5'd7; wr_data = 64'h1234_5678_9ABC_DEF0;
    rd2_addr = 5'd7; #1;
    chk("R4 old value", 96'(rd2_data), 96'(model[7]));
    chk("R4 old hi tap", 96'(rd3_hi_data), 96'(model[7]));
    @(negedge clk);
    wr_en = 1'b0; model[7] = 64'h1234_5678_9ABC_DEF0; #1;
    chk("R2 new value", 96'(rd2_data), 96'(model[7]));
    chk("R5 new hi tap", 96'(rd3_hi_data), 96'(model[7]));

    // R9: live data with strobe low changes nothing
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 5'd12; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    wr_addr = 5'd13;
    @(negedge clk);
    for (int a = 0; a < 32; a++) begin
      rd1_addr = 5'(a); #1;
      chk("R9 no write", 96'(rd1_data), 96'(model[a]));
    end

    // Second pattern, rewritten in reverse order
    for (int a = 31; a >= 0; a--) write_reg(a, pat(a, 32'h5A3C_F0E1));
    sweep_all();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule